// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from the functional units of a wireless device and presents them to a host processor as sticky status bits behind one interrupt line. Each implemented source has its own status bit. A pulse sets the bit, and the bit stays set until the host clears it. The host sees the bits through a small synchronous register interface.

The host can look at the status in two ways. One read port leaves the bits untouched. The other returns them and empties the whole register in the same access. A write-one-to-acknowledge port clears chosen bits. A mask register decides which sources may raise the interrupt line. The mask can be written whole, or changed one bit at a time through separate write-one-to-set and write-one-to-clear ports, so no read-modify-write is needed.

A configuration register turns the interrupt pin on and selects its polarity. The pin is registered, so it changes one cycle after the status, mask or configuration that drives it.

Top module: `host_irq_agg`

## Requirements
- R1: After reset the mask reads 0x00001, the status reads 0, the configuration reads 0 and `irq_out` is 0.
- R2: A 1 on `evt[i]` for an implemented source sets status bit i at that clock edge. The bit stays set until it is cleared. The implemented sources are bits 0 to 10 (receive buffer 0 data, transmit data, transmit transfer, receive buffer 1 data, receive transfer, event mailbox A and B, wake-on-host, trace A and B, command complete), bit 14 (init complete), bit 16 (coexistence sense on) and bit 17 (coexistence sense off). Bits 11, 12, 13 and 15 never become set and always read 0.
- R3: A read at offset 4 returns the status and leaves it unchanged.
- R4: A read at offset 5 returns the status as it was before the access and clears every status bit.
- R5: A write at offset 6 clears each status bit whose `wdata` bit is 1. Bits written as 0 keep their value.
- R6: A write at offset 1 loads the mask. A write at offset 2 sets each mask bit whose `wdata` bit is 1. A write at offset 3 clears each mask bit whose `wdata` bit is 1. In all three cases a mask bit of 1 suppresses its source.
- R7: The interrupt is active when some status bit is 1 while its mask bit is 0, and only while configuration bit 5 is 1. `irq_out` carries this value inverted when configuration bit 7 is 1. It follows the state one cycle later.
- R8: When an event pulse lands on a bit in the same cycle as a clear of that bit by read at offset 5 or acknowledge, the bit ends up set. The read still returns the value from before the access.
- R9: Read data appears on `rdata` in the cycle after `rd_en`. The configuration register at offset 0 keeps only bits 5 and 7. Offsets 2, 3, 6 and 7 read as 0.
- R10: Writes to offsets 4, 5 and 7 change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| evt | input | 18 | Single-cycle event pulses, one per source bit |
| irq_out | output | 1 | Host interrupt line |

## Verification
The bench aims at the collision cases first. An event that lands in the same cycle as a clear-on-read or an acknowledge must survive. A design that lets the clear win drops an interrupt, and the bench sees that as a missing bit on the next non-destructive read. The clear-on-read port must return the value from before the clear. A design that samples after clearing reads back zero.

The set and clear mask ports must touch only the bits written as 1. A design that loads the written value instead corrupts the other mask bits, and the bench sees this when it reads the mask back. The bench also pulses the reserved source bits and checks that they stay zero. It sweeps the enable and polarity bits, where an inverted level or a polarity applied before the enable gate shows up on `irq_out`.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int SRC_W = 18;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [SRC_W-1:0] SRC_IMPL = 18'h347FF;
  localparam logic [SRC_W-1:0] MASK_INIT = 18'h00001;
  localparam int CFG_EN_BIT = 5;
  localparam int CFG_LOW_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_MSET = 3'd2,
    SEL_MCLR = 3'd3,
    SEL_PEEK = 3'd4,
    SEL_TAKE = 3'd5,
    SEL_ACK  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic cfg_wr;
    logic mask_wr;
    logic mset_wr;
    logic mclr_wr;
    logic ack_wr;
    logic take_rd;
  } strobe_t;
endpackage

// File: rtl/host_irq_decode.sv
module host_irq_decode
  import host_irq_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  reg_sel_e sel;

  always_comb begin
    sel = reg_sel_e'(addr);
    stb = '0;
    case (sel)
      SEL_CFG:  stb.cfg_wr  = wr_en;
      SEL_MASK: stb.mask_wr = wr_en;
      SEL_MSET: stb.mset_wr = wr_en;
      SEL_MCLR: stb.mclr_wr = wr_en;
      SEL_ACK:  stb.ack_wr  = wr_en;
      SEL_TAKE: stb.take_rd = rd_en;
      default:  stb = '0;
    endcase
  end
endmodule

// File: rtl/host_irq_status.sv
module host_irq_status #(
  parameter int               SRC_W = 18,
  parameter logic [SRC_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt,
  input  logic             take,
  input  logic             ack,
  input  logic [SRC_W-1:0] ack_bits,
  output logic [SRC_W-1:0] status
);
  logic [SRC_W-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (take)     clr_vec = '1;
    else if (ack) clr_vec = ack_bits;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_q;
      logic bit_d;
      logic bit_ce;

      always_comb begin
        bit_ce = evt[i] | clr_vec[i];
        bit_d  = evt[i] | (bit_q & ~clr_vec[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_ce) bit_q <= bit_d;
      end

      assign status[i] = bit_q;
    end else begin : g_resv
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/host_irq_mask.sv
module host_irq_mask #(
  parameter int               SRC_W = 18,
  parameter logic [SRC_W-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             set,
  input  logic             clr,
  input  logic [SRC_W-1:0] bits,
  output logic [SRC_W-1:0] mask
);
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;
  logic             mask_ce;

  always_comb begin
    mask_ce = load | set | clr;
    mask_d  = mask_q;
    if (load)     mask_d = bits;
    else if (set) mask_d = mask_q | bits;
    else if (clr) mask_d = mask_q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= INIT;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/host_irq_pin.sv
module host_irq_pin #(
  parameter int SRC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] status,
  input  logic [SRC_W-1:0] mask,
  input  logic             enable,
  input  logic             active_low,
  output logic             irq
);
  logic pend;
  logic irq_d;
  logic irq_q;

  always_comb begin
    pend  = |(status & ~mask);
    irq_d = (pend & enable) ^ active_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/host_irq_agg.sv
module host_irq_agg
  import host_irq_pkg::*;
#(
  parameter int                  P_SRC_W  = SRC_W,
  parameter int                  P_DATA_W = DATA_W,
  parameter logic [P_SRC_W-1:0]  P_IMPL   = SRC_IMPL,
  parameter logic [P_SRC_W-1:0]  P_MINIT  = MASK_INIT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_DATA_W-1:0] rdata,
  input  logic [P_SRC_W-1:0]  evt,
  output logic                irq_out
);
  localparam int PAD_W = P_DATA_W - P_SRC_W;

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  strobe_t             stb;
  logic [P_SRC_W-1:0]  wbits;
  logic [P_SRC_W-1:0]  status;
  logic [P_SRC_W-1:0]  mask;
  logic                cfg_en;
  logic                cfg_low;
  logic                cfg_en_d;
  logic                cfg_low_d;
  logic [P_DATA_W-1:0] rd_mux;
  logic [P_DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign wbits = wdata[P_SRC_W-1:0];

  host_irq_decode u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .stb   (stb)
  );

  host_irq_status #(.SRC_W(P_SRC_W), .IMPL(P_IMPL)) u_sts (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (evt),
    .take     (stb.take_rd),
    .ack      (stb.ack_wr),
    .ack_bits (wbits),
    .status   (status)
  );

  host_irq_mask #(.SRC_W(P_SRC_W), .INIT(P_MINIT)) u_msk (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (stb.mask_wr),
    .set   (stb.mset_wr),
    .clr   (stb.mclr_wr),
    .bits  (wbits),
    .mask  (mask)
  );

  always_comb begin
    cfg_en_d  = cfg_en;
    cfg_low_d = cfg_low;
    if (stb.cfg_wr) begin
      cfg_en_d  = wdata[CFG_EN_BIT];
      cfg_low_d = wdata[CFG_LOW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_en  <= 1'b0;
      cfg_low <= 1'b0;
    end else if (stb.cfg_wr) begin
      cfg_en  <= cfg_en_d;
      cfg_low <= cfg_low_d;
    end
  end

  host_irq_pin #(.SRC_W(P_SRC_W)) u_pin (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .status     (status),
    .mask       (mask),
    .enable     (cfg_en),
    .active_low (cfg_low),
    .irq        (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(addr))
      SEL_CFG: begin
        rd_mux[CFG_EN_BIT]  = cfg_en;
        rd_mux[CFG_LOW_BIT] = cfg_low;
      end
      SEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask};
      SEL_PEEK: rd_mux = {{PAD_W{1'b0}}, status};
      SEL_TAKE: rd_mux = {{PAD_W{1'b0}}, status};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/host_irq_chk.sv
module host_irq_chk #(
  parameter int               SRC_W = 18,
  parameter logic [SRC_W-1:0] IMPL  = '1
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [SRC_W-1:0] evt,
  input logic [SRC_W-1:0] status,
  input logic [SRC_W-1:0] mask,
  input logic             cfg_en,
  input logic             cfg_low,
  input logic             irq_out
);
  logic clr_any;
  assign clr_any = (rd_en && addr == 3'd5) || (wr_en && addr == 3'd6);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status & ~IMPL) == '0);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clr_any |=> (status & $past(status)) == $past(status));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (status & $past(evt & IMPL)) == $past(evt & IMPL));

  a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && addr == 3'd4 && !wr_en && evt == '0) |=> status == $past(status));

  a_r4_take_empties: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && addr == 3'd5 && evt == '0) |=> status == '0);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 3'd6) |=> (status & $past(wdata[SRC_W-1:0] & ~evt)) == '0);

  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 3'd2) |=> mask == ($past(mask) | $past(wdata[SRC_W-1:0])));

  a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 3'd3) |=> mask == ($past(mask) & ~$past(wdata[SRC_W-1:0])));

  a_r7_pin_level: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> irq_out == ($past(cfg_en && ((status & ~mask) != '0)) ^ $past(cfg_low)));
endmodule

bind host_irq_agg host_irq_chk #(.SRC_W(P_SRC_W), .IMPL(P_IMPL)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .evt       (evt),
  .status    (status),
  .mask      (mask),
  .cfg_en    (cfg_en),
  .cfg_low   (cfg_low),
  .irq_out   (irq_out)
);

// File: tb/tb_host_irq_agg.sv
`timescale 1ns/1ps
module tb_host_irq_agg;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [17:0] evt;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  host_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [17:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    check(req, {31'd0, irq_out}, {31'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(3'd1, v); check("R1 mask reset", v, 32'h1);
    rd(3'd4, v); check("R1 status reset", v, 32'h0);
    rd(3'd0, v); check("R1 cfg reset", v, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    pulse(18'h00002);
    rd(3'd4, v); check("R2 event sets bit 1", v, 32'h2);
    pulse(18'h24008);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R2 sticky bits 1 3 14 17", v, 32'h2400A);
    pulse(18'h0B800);
    rd(3'd4, v); check("R2 reserved bits stay zero", v, 32'h2400A);
    rd(3'd4, v); check("R3 peek leaves status", v, 32'h2400A);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(3'd6, 32'h0);
    rd(3'd4, v); check("R5 zero ack no effect", v, 32'h2400A);
    wr(3'd6, 32'h20002);
    rd(3'd4, v); check("R5 ack clears chosen bits", v, 32'h04008);
  endtask

  task automatic t_take();
    logic [31:0] v;
    pulse(18'h10401);
    rd(3'd5, v); check("R4 take returns old status", v, 32'h14409);
    rd(3'd4, v); check("R4 take cleared all", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd2, 32'h30);
    rd(3'd1, v); check("R6 mask set", v, 32'h31);
    wr(3'd3, 32'h11);
    rd(3'd1, v); check("R6 mask clear", v, 32'h20);
    wr(3'd1, 32'h3FFFF);
    rd(3'd1, v); check("R6 mask load", v, 32'h3FFFF);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulse(18'h00001);
    chk_irq("R7 disabled stays low", 1'b0);
    wr(3'd0, 32'h20);
    chk_irq("R7 enabled active high", 1'b1);
    wr(3'd2, 32'h1);
    chk_irq("R7 masked source", 1'b0);
    wr(3'd0, 32'hA0);
    chk_irq("R7 active low idle", 1'b1);
    wr(3'd3, 32'h1);
    chk_irq("R7 active low asserted", 1'b0);
    wr(3'd0, 32'h80);
    chk_irq("R7 disabled active low", 1'b1);
    rd(3'd0, v); check("R9 cfg keeps bits 5 and 7", v, 32'h80);
    wr(3'd0, 32'hFFFF_FF5F);
    rd(3'd0, v); check("R9 cfg other bits dropped", v, 32'h0);
    chk_irq("R7 back to idle low", 1'b0);
    wr(3'd6, 32'h1);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pulse(18'h00004);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'd5; evt = 18'h00002;
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
    check("R8 take returns value before access", rdata, 32'h4);
    rd(3'd4, v); check("R8 event survives take", v, 32'h2);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wdata = 32'h2; evt = 18'h00002;
    @(negedge clk);
    wr_en = 1'b0; evt = '0; wdata = '0;
    rd(3'd4, v); check("R8 event survives ack", v, 32'h2);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(3'd4, 32'h3FFFF);
    wr(3'd5, 32'h3FFFF);
    wr(3'd7, 32'h3FFFF);
    rd(3'd4, v); check("R10 status writes ignored", v, 32'h2);
    rd(3'd1, v); check("R10 mask untouched", v, 32'h0);
    rd(3'd2, v); check("R9 set port reads zero", v, 32'h0);
    rd(3'd3, v); check("R9 clear port reads zero", v, 32'h0);
    rd(3'd6, v); check("R9 ack port reads zero", v, 32'h0);
    rd(3'd7, v); check("R9 unused offset reads zero", v, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sticky();
    t_ack();
    t_take();
    t_mask();
    t_irq();
    t_race();
    t_ignored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule